// File: doc/BRIEF.md
# Product-Term Steering Allocator

This block steers the product terms of one programmable logic block into per-cell sum-of-products results. The logic block holds a row of steering cells (18 by default), each of which owns five locally formed product terms. Static configuration bits decide, term by term, whether a term joins the cell's own OR sum, leaves the sum to serve as a control signal, or is sent to a neighbouring cell as part of a partial sum.

Partial sums travel along two chains, one toward higher cell indices ("up") and one toward lower indices ("down"). A cell either absorbs the partial sum that reaches it from a given side into its own result, or lets it continue past. A partial sum that passes picks up any terms the cell exports in that direction. Chaining lets one cell collect the terms of every other cell in the block. For each cell the block also reports its logic span: the distance in cells to the farthest cell whose exported terms it absorbs.

The results are registered once. A synchronous reset clears every output.

Top module: `pts_steer_alloc`

## Requirements
- R1: Cell c owns terms `termVec[c*5 +: 5]`. Its configuration word is `cfgVec[c*18 +: 18]`, laid out as: bits 4:0 sum-enable, 9:5 control-enable, 14:10 export-enable, 15 absorb-from-below, 16 absorb-from-above, 17 export-up. A term whose sum-enable is set and whose export-enable is clear joins the cell's OR sum. A cell with no such term and no absorb bit has a sum of 0.
- R2: `ctlOut[c*5+k]` equals term k of cell c ANDed with control-enable bit k. It is independent of the sum and export settings.
- R3: A term with export-enable set is removed from its own cell's sum, even if its sum-enable is set. It is ORed into the partial sum leaving the cell upward (to c+1) when export-up is 1, and downward (to c-1) when export-up is 0.
- R4: A cell with absorb-from-below set ORs the upward partial sum arriving from cell c-1 into its own sum and does not pass that sum on. Absorb-from-above does the same for the downward partial sum arriving from cell c+1.
- R5: A cell that does not absorb from a side passes the partial sum arriving from that side on unchanged, ORed with its own exports in that direction. A single cell can therefore collect the terms of all cells in the block.
- R6: The lowest cell receives 0 from below and the highest cell receives 0 from above.
- R7: A cell's own summed terms reach its sum whatever partial sums it absorbs.
- R8: `spanOut[c*5 +: 5]` gives, as an unsigned number, the largest |c-j| over all cells j that have at least one export-enable bit set and whose partial sum is absorbed by cell c. It is 0 when the cell uses only its own terms. The span depends on configuration only, not on term values.
- R9: `cfgErr[c]` is 1 when any term of cell c has more than one of its sum, control and export enables set.
- R10: All outputs are registered and change on the clock edge after their inputs change. While `rst` is high at a rising edge, all outputs go to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgVec | input | NUM_CELLS*18 | Static steering configuration, 18 bits per cell |
| termVec | input | NUM_CELLS*5 | Product terms, 5 per cell |
| sumOut | output | NUM_CELLS | Registered sum-of-products result per cell |
| ctlOut | output | NUM_CELLS*5 | Registered control-use terms |
| spanOut | output | NUM_CELLS*5 | Registered logic span per cell |
| cfgErr | output | NUM_CELLS | Registered conflicting-use flag per cell |

## Verification
In a single cycle, one cell can both absorb a neighbour's partial sum and pass a partial sum coming from the other side. The same cell's own terms feed its sum at that time. Random configurations with many absorb bits set produce this overlap. A path-walking reference model judges every cell: for each source cell, it asks whether every cell in between lets the sum through and whether the target absorbs it. A directed case sends partial sums from both ends of the row into one middle cell, and a conflicting-use case checks that the exported copy of a term wins over the local sum.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int TERMS_PER_CELL = 5;
  localparam int CFG_BITS = 3 * TERMS_PER_CELL + 3;

  // Decoded per-cell strobes passed from the control to the datapath
  typedef struct packed {
    logic [TERMS_PER_CELL-1:0] sumMask;
    logic [TERMS_PER_CELL-1:0] ctlMask;
    logic [TERMS_PER_CELL-1:0] expMask;
    logic takeLow;
    logic takeHigh;
    logic expUp;
  } cellStrobe_t;
endpackage

// File: rtl/pts_steer_ctrl.sv
module pts_steer_ctrl import pts_pkg::*; #(
  parameter int NUM_CELLS = 18,
  parameter int SPAN_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_CELLS*CFG_BITS-1:0] cfgVec,
  output cellStrobe_t strb [NUM_CELLS],
  output logic [SPAN_W-1:0] span [NUM_CELLS],
  output logic [NUM_CELLS-1:0] err
);
  localparam int T = TERMS_PER_CELL;

  logic [T-1:0] sumEn [NUM_CELLS];
  logic [T-1:0] ctlEn [NUM_CELLS];
  logic [T-1:0] expEn [NUM_CELLS];
  logic takeLow [NUM_CELLS];
  logic takeHigh [NUM_CELLS];
  logic expUp [NUM_CELLS];

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_dec
    assign sumEn[c]    = cfgVec[c*CFG_BITS +: T];
    assign ctlEn[c]    = cfgVec[c*CFG_BITS + T +: T];
    assign expEn[c]    = cfgVec[c*CFG_BITS + 2*T +: T];
    assign takeLow[c]  = cfgVec[c*CFG_BITS + 3*T];
    assign takeHigh[c] = cfgVec[c*CFG_BITS + 3*T + 1];
    assign expUp[c]    = cfgVec[c*CFG_BITS + 3*T + 2];

    // export wins over the local sum (R3)
    assign strb[c].sumMask  = sumEn[c] & ~expEn[c];
    assign strb[c].ctlMask  = ctlEn[c];
    assign strb[c].expMask  = expEn[c];
    assign strb[c].takeLow  = takeLow[c];
    assign strb[c].takeHigh = takeHigh[c];
    assign strb[c].expUp    = expUp[c];
    assign err[c] = |((sumEn[c] & ctlEn[c]) | (sumEn[c] & expEn[c]) | (ctlEn[c] & expEn[c]));
  end

  // Span tracking: validity and farthest-source distance on each chain
  logic upV [NUM_CELLS];
  logic [SPAN_W-1:0] upD [NUM_CELLS];
  logic upArrV [NUM_CELLS];
  logic [SPAN_W-1:0] upArrD [NUM_CELLS];
  logic dnV [NUM_CELLS];
  logic [SPAN_W-1:0] dnD [NUM_CELLS];
  logic dnArrV [NUM_CELLS];
  logic [SPAN_W-1:0] dnArrD [NUM_CELLS];

  always_comb begin
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (i == 0) begin
        upArrV[i] = 1'b0;
        upArrD[i] = '0;
      end else begin
        upArrV[i] = upV[i-1];
        upArrD[i] = upD[i-1] + SPAN_W'(1);
      end
      upV[i] = (upArrV[i] & ~takeLow[i]) | (expUp[i] & (|expEn[i]));
      upD[i] = (upArrV[i] & ~takeLow[i]) ? upArrD[i] : '0;
    end
    for (int i = NUM_CELLS - 1; i >= 0; i--) begin
      if (i == NUM_CELLS - 1) begin
        dnArrV[i] = 1'b0;
        dnArrD[i] = '0;
      end else begin
        dnArrV[i] = dnV[i+1];
        dnArrD[i] = dnD[i+1] + SPAN_W'(1);
      end
      dnV[i] = (dnArrV[i] & ~takeHigh[i]) | (~expUp[i] & (|expEn[i]));
      dnD[i] = (dnArrV[i] & ~takeHigh[i]) ? dnArrD[i] : '0;
    end
  end

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_span
    logic [SPAN_W-1:0] fromLow, fromHigh;
    assign fromLow  = (upArrV[c] & takeLow[c])  ? upArrD[c] : '0;
    assign fromHigh = (dnArrV[c] & takeHigh[c]) ? dnArrD[c] : '0;
    assign span[c]  = (fromLow > fromHigh) ? fromLow : fromHigh;

    // R8: a cell that absorbs nothing has span 0
    p_span_local_r8: assert property (@(posedge clk) disable iff (rst)
      (!strb[c].takeLow && !strb[c].takeHigh) |-> (span[c] == '0));
  end
endmodule

// File: rtl/pts_steer_dp.sv
module pts_steer_dp import pts_pkg::*; #(
  parameter int NUM_CELLS = 18,
  parameter int SPAN_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_CELLS*TERMS_PER_CELL-1:0] termVec,
  input  cellStrobe_t strb [NUM_CELLS],
  input  logic [SPAN_W-1:0] span [NUM_CELLS],
  input  logic [NUM_CELLS-1:0] err,
  output logic [NUM_CELLS-1:0] sumOut,
  output logic [NUM_CELLS*TERMS_PER_CELL-1:0] ctlOut,
  output logic [NUM_CELLS*SPAN_W-1:0] spanOut,
  output logic [NUM_CELLS-1:0] cfgErr
);
  localparam int T = TERMS_PER_CELL;

  logic [NUM_CELLS-1:0] localOr, expOr;
  logic upBus [NUM_CELLS];
  logic upArr [NUM_CELLS];
  logic dnBus [NUM_CELLS];
  logic dnArr [NUM_CELLS];
  logic [NUM_CELLS-1:0] sumNext;
  logic [NUM_CELLS*T-1:0] ctlNext;
  logic [NUM_CELLS*SPAN_W-1:0] spanNext;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_term
    assign localOr[c] = |(termVec[c*T +: T] & strb[c].sumMask);
    assign expOr[c]   = |(termVec[c*T +: T] & strb[c].expMask);
    assign ctlNext[c*T +: T] = termVec[c*T +: T] & strb[c].ctlMask;
    assign spanNext[c*SPAN_W +: SPAN_W] = span[c];
  end

  // Partial-sum chains; ends tied to zero (R6)
  always_comb begin
    for (int i = 0; i < NUM_CELLS; i++) begin
      upArr[i] = (i == 0) ? 1'b0 : upBus[i-1];
      upBus[i] = (upArr[i] & ~strb[i].takeLow) | (expOr[i] & strb[i].expUp);
    end
    for (int i = NUM_CELLS - 1; i >= 0; i--) begin
      dnArr[i] = (i == NUM_CELLS - 1) ? 1'b0 : dnBus[i+1];
      dnBus[i] = (dnArr[i] & ~strb[i].takeHigh) | (expOr[i] & ~strb[i].expUp);
    end
    for (int i = 0; i < NUM_CELLS; i++) begin
      sumNext[i] = localOr[i] | (strb[i].takeLow & upArr[i]) | (strb[i].takeHigh & dnArr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumOut  <= '0;
      ctlOut  <= '0;
      spanOut <= '0;
      cfgErr  <= '0;
    end else begin
      sumOut  <= sumNext;
      ctlOut  <= ctlNext;
      spanOut <= spanNext;
      cfgErr  <= err;
    end
  end

  // R10: reset clears all outputs on the next edge
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (sumOut == '0 && ctlOut == '0 && spanOut == '0 && cfgErr == '0));

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
    // R2: no control output without its enable
    p_ctl_gate_r2: assert property (@(posedge clk) disable iff (rst)
      (ctlOut[c*T +: T] & ~$past(strb[c].ctlMask)) == '0);
    // R1: a cell with nothing summed and nothing absorbed yields 0
    p_idle_sum_r1: assert property (@(posedge clk) disable iff (rst)
      (strb[c].sumMask == '0 && !strb[c].takeLow && !strb[c].takeHigh) |=> !sumOut[c]);
  end
endmodule

// File: rtl/pts_steer_alloc.sv
module pts_steer_alloc import pts_pkg::*; #(
  parameter int NUM_CELLS = 18,
  localparam int SPAN_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_CELLS*CFG_BITS-1:0] cfgVec,
  input  logic [NUM_CELLS*TERMS_PER_CELL-1:0] termVec,
  output logic [NUM_CELLS-1:0] sumOut,
  output logic [NUM_CELLS*TERMS_PER_CELL-1:0] ctlOut,
  output logic [NUM_CELLS*SPAN_W-1:0] spanOut,
  output logic [NUM_CELLS-1:0] cfgErr
);
  cellStrobe_t strb [NUM_CELLS];
  logic [SPAN_W-1:0] span [NUM_CELLS];
  logic [NUM_CELLS-1:0] err;

  pts_steer_ctrl #(.NUM_CELLS(NUM_CELLS), .SPAN_W(SPAN_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfgVec(cfgVec), .strb(strb), .span(span), .err(err));

  pts_steer_dp #(.NUM_CELLS(NUM_CELLS), .SPAN_W(SPAN_W)) u_dp (
    .clk(clk), .rst(rst), .termVec(termVec), .strb(strb), .span(span), .err(err),
    .sumOut(sumOut), .ctlOut(ctlOut), .spanOut(spanOut), .cfgErr(cfgErr));
endmodule

// File: tb/pts_steer_alloc_tb.sv
module pts_steer_alloc_tb;
  import pts_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 18;
  localparam int T = TERMS_PER_CELL;
  localparam int CB = CFG_BITS;
  localparam int SW = $clog2(N);

  // stimulus table: {dirty flag, seed}
  localparam logic [32:0] VEC [10] = '{
    {1'b0, 32'h1234_5678}, {1'b0, 32'hDEAD_BEEF}, {1'b0, 32'h0BAD_F00D},
    {1'b0, 32'h7777_1111}, {1'b1, 32'hCAFE_0001}, {1'b1, 32'h5555_AAAA},
    {1'b0, 32'h0000_0101}, {1'b1, 32'h9E37_79B9}, {1'b0, 32'h3141_5926},
    {1'b0, 32'h2718_2818}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*CB-1:0] cfgVec = '0;
  logic [N*T-1:0] termVec = '0;
  logic [N-1:0] sumOut;
  logic [N*T-1:0] ctlOut;
  logic [N*SW-1:0] spanOut;
  logic [N-1:0] cfgErr;

  int checks = 0;
  int errors = 0;

  logic expSum [N];
  int expSpan [N];
  logic expErr [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  pts_steer_alloc #(.NUM_CELLS(N)) u_dut (
    .clk(clk), .rst(rst), .cfgVec(cfgVec), .termVec(termVec),
    .sumOut(sumOut), .ctlOut(ctlOut), .spanOut(spanOut), .cfgErr(cfgErr));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [T-1:0] fSum(input int c);  return cfgVec[c*CB +: T];       endfunction
  function automatic logic [T-1:0] fCtl(input int c);  return cfgVec[c*CB + T +: T];   endfunction
  function automatic logic [T-1:0] fExp(input int c);  return cfgVec[c*CB + 2*T +: T]; endfunction
  function automatic logic fLow(input int c);  return cfgVec[c*CB + 3*T];     endfunction
  function automatic logic fHigh(input int c); return cfgVec[c*CB + 3*T + 1]; endfunction
  function automatic logic fUp(input int c);   return cfgVec[c*CB + 3*T + 2]; endfunction

  // Path-walking reference model
  task automatic compute_ref();
    for (int i = 0; i < N; i++) begin
      logic s;
      int sp;
      s = |(termVec[i*T +: T] & fSum(i) & ~fExp(i));
      sp = 0;
      for (int j = 0; j < N; j++) begin
        logic ok;
        ok = 1'b0;
        if (j < i && fExp(j) != '0 && fUp(j) && fLow(i)) begin
          ok = 1'b1;
          for (int k = j + 1; k < i; k++) if (fLow(k)) ok = 1'b0;
        end
        if (j > i && fExp(j) != '0 && !fUp(j) && fHigh(i)) begin
          ok = 1'b1;
          for (int k = i + 1; k < j; k++) if (fHigh(k)) ok = 1'b0;
        end
        if (ok) begin
          s = s | (|(termVec[j*T +: T] & fExp(j)));
          if ((i > j ? i - j : j - i) > sp) sp = (i > j ? i - j : j - i);
        end
      end
      expSum[i] = s;
      expSpan[i] = sp;
      expErr[i] = |((fSum(i) & fCtl(i)) | (fSum(i) & fExp(i)) | (fCtl(i) & fExp(i)));
    end
  endtask

  task automatic check_all();
    compute_ref();
    for (int i = 0; i < N; i++) begin
      chk("R1/R3/R4/R5", $sformatf("sum cell %0d", i), int'(sumOut[i]), int'(expSum[i]));
      chk("R8", $sformatf("span cell %0d", i), int'(spanOut[i*SW +: SW]), expSpan[i]);
      chk("R9", $sformatf("err cell %0d", i), int'(cfgErr[i]), int'(expErr[i]));
      chk("R2", $sformatf("ctl cell %0d", i), int'(ctlOut[i*T +: T]),
          int'(termVec[i*T +: T] & fCtl(i)));
    end
  endtask

  task automatic gen(input logic [31:0] seed, input logic dirty);
    logic [31:0] st;
    st = seed;
    cfgVec = '0;
    for (int c = 0; c < N; c++) begin
      for (int t = 0; t < T; t++) begin
        st = xs(st);
        case (st[1:0])
          2'd1: cfgVec[c*CB + t] = 1'b1;
          2'd2: cfgVec[c*CB + T + t] = 1'b1;
          2'd3: cfgVec[c*CB + 2*T + t] = 1'b1;
          default: ;
        endcase
        if (dirty && st[4:2] == 3'd0) cfgVec[c*CB + t] = 1'b1;
      end
      st = xs(st);
      cfgVec[c*CB + 3*T]     = st[3] & st[4];
      cfgVec[c*CB + 3*T + 1] = st[5] & st[6];
      cfgVec[c*CB + 3*T + 2] = st[7];
    end
    for (int w = 0; w < N*T; w++) begin
      st = xs(st);
      termVec[w] = st[9];
    end
  endtask

  task automatic apply_and_check();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state with busy inputs
    gen(32'hFFFF_0F0F, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10", "sum in reset", int'(sumOut), 0);
    chk("R10", "ctl in reset", int'(ctlOut != '0), 0);
    chk("R10", "span in reset", int'(spanOut != '0), 0);
    chk("R10", "err in reset", int'(cfgErr), 0);
    rst = 1'b0;

    // table walk
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      gen(VEC[v][31:0], VEC[v][32]);
      apply_and_check();
    end

    // R5/R8: cell 8 collects every other cell
    @(negedge clk);
    cfgVec = '0;
    termVec = '0;
    for (int c = 0; c < N; c++) begin
      if (c == 8) begin
        cfgVec[c*CB +: T] = '1;
        cfgVec[c*CB + 3*T] = 1'b1;
        cfgVec[c*CB + 3*T + 1] = 1'b1;
      end else begin
        cfgVec[c*CB + 2*T +: T] = '1;
        cfgVec[c*CB + 3*T + 2] = (c < 8);
      end
    end
    termVec[0] = 1'b1;
    apply_and_check();
    chk("R5", "collect from cell 0", int'(sumOut[8]), 1);
    chk("R8", "collect span", int'(spanOut[8*SW +: SW]), 9);
    @(negedge clk);
    termVec = '0;
    termVec[17*T + 4] = 1'b1;
    apply_and_check();
    chk("R5", "collect from cell 17", int'(sumOut[8]), 1);
    @(negedge clk);
    termVec = '0;
    apply_and_check();
    chk("R5", "collect all zero", int'(sumOut[8]), 0);
    chk("R8", "span independent of terms", int'(spanOut[8*SW +: SW]), 9);

    // R6: chain ends see zero
    @(negedge clk);
    cfgVec = '0;
    cfgVec[0*CB + 3*T] = 1'b1;
    cfgVec[17*CB + 3*T + 1] = 1'b1;
    termVec = '1;
    apply_and_check();
    chk("R6", "lowest cell from below", int'(sumOut[0]), 0);
    chk("R6", "highest cell from above", int'(sumOut[17]), 0);
    chk("R6", "end span", int'(spanOut[0 +: SW]), 0);

    // R9/R3: term both summed and exported
    @(negedge clk);
    cfgVec = '0;
    termVec = '0;
    cfgVec[3*CB + 2] = 1'b1;
    cfgVec[3*CB + 2*T + 2] = 1'b1;
    cfgVec[3*CB + 3*T + 2] = 1'b1;
    cfgVec[4*CB + 3*T] = 1'b1;
    termVec[3*T + 2] = 1'b1;
    apply_and_check();
    chk("R9", "conflict flag", int'(cfgErr[3]), 1);
    chk("R3", "exported term left local sum", int'(sumOut[3]), 0);
    chk("R3", "exported term reached upper neighbour", int'(sumOut[4]), 1);
    chk("R8", "one-hop span", int'(spanOut[4*SW +: SW]), 1);

    // R7: own term still reaches sum while absorbing a zero partial sum
    @(negedge clk);
    cfgVec = '0;
    termVec = '0;
    cfgVec[5*CB + 0] = 1'b1;
    cfgVec[5*CB + 3*T] = 1'b1;
    cfgVec[4*CB + 2*T + 1] = 1'b1;
    cfgVec[4*CB + 3*T + 2] = 1'b1;
    termVec[5*T + 0] = 1'b1;
    apply_and_check();
    chk("R7", "own term with borrowing", int'(sumOut[5]), 1);

    // R10: output holds until the next rising edge
    @(negedge clk);
    termVec[5*T + 0] = 1'b0;
    #1;
    chk("R10", "no change before edge", int'(sumOut[5]), 1);
    @(negedge clk);
    chk("R10", "update after edge", int'(sumOut[5]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule